// File: doc/BRIEF.md
# Compression-Factor Skewed Set-Index Generator

This unit turns one requested block address into every candidate location of a compressed last-level cache in which blocks are grouped into aligned superblocks of eight. The cache is split into four way groups. The compression factor (CF) that a group can hold for a given superblock comes from that group's number and two low superblock-tag bits. For every way of every group the unit then produces a set index. The index is an XOR-fold of the upper tag bits, of those block-offset bits that the CF still distinguishes, and of the CF itself, followed by a rotation that differs for each way. Blocks that share one physical slot at a given CF therefore always land on the same index, and each way scatters its conflicts differently.

A second port serves a rewrite whose data has moved to a new CF. It takes the address and the new CF and returns the one destination way group together with the per-way set indices for that CF. Both ports are purely combinational by default. A parameter can add one register stage at the output.

Top module: `skew_index_gen`

## Requirements
- R1: For each way group g (0..3), `lookup_cf[g]` equals `lookup_addr[4:3] XOR g`.
- R2: `move_group` equals `move_addr[4:3] XOR move_cf`.
- R3: Address fields are as follows: bits [2:0] select the block inside the superblock, bits [4:3] are the group-select tag bits, and bits above 4 are the remaining tag. For a fixed CF, changing only bits [4:3] leaves every set index unchanged.
- R4: The hash input is the vector {addr[ADDR_W-1:5], offset AND keep-mask, cf}, with cf in bits [1:0] and the masked offset in bits [4:2]. It is zero-padded at the top and XOR-folded in IDX_W-bit chunks to give the index of way 0.
- R5: The keep-mask is 3'b111 for CF0, 3'b110 for CF1, 3'b100 for CF2 and 3'b000 for CF3. At CF0 the eight offsets of one superblock give eight distinct indices.
- R6: Offsets that differ only in bits the keep-mask clears give identical indices: pairs at CF1, halves at CF2, and the whole superblock at CF3.
- R7: The index of way k is the way-0 index rotated left by k mod IDX_W bits.
- R8: `move_idx` equals `lookup_idx[move_group]` whenever both ports carry the same address.
- R9: With REG_OUT=0 every output is valid in the same cycle as its inputs. With REG_OUT=1 the outputs appear one clock later, and they are zero while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| lookup_addr | input | ADDR_W | Block address being searched |
| lookup_cf | output | 4x2 | CF that each way group holds for lookup_addr |
| lookup_idx | output | 4xWAYSxIDX_W | Set index for every way of every group |
| move_addr | input | ADDR_W | Block address whose CF changes |
| move_cf | input | 2 | New compression factor |
| move_group | output | 2 | Destination way group |
| move_idx | output | WAYSxIDX_W | Set indices in the destination group |

## Verification
The hardest case to reach from the ports is the proof that an offset bit is really ignored at a given CF. Nothing at the ports shows which offset bits reach the hash. On the lookup port each CF appears in a different group for each address, so the bench uses the move port to pin the CF. It then sweeps all eight offsets of one superblock at each CF and compares every pair of indices for equality or inequality. The lookup port is then driven with the same address, which confirms that the group chosen by the move port carries the same indices.

// File: rtl/sc_idx_pkg.sv
package sc_idx_pkg;

    localparam int NUM_GROUPS = 4;
    localparam int GRP_W      = 2;
    localparam int OFF_W      = 3;
    localparam int SEL_LO     = OFF_W;
    localparam int TAG_LO     = OFF_W + GRP_W;

    typedef logic [GRP_W-1:0] cf_t;

    // offset bits that still separate blocks at a given compression factor
    function automatic logic [OFF_W-1:0] off_keep(input cf_t cf);
        unique case (cf)
            2'd0:    off_keep = 3'b111;
            2'd1:    off_keep = 3'b110;
            2'd2:    off_keep = 3'b100;
            default: off_keep = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/sc_fold_rot.sv
module sc_fold_rot #(
    parameter int IN_W  = 32,
    parameter int IDX_W = 8,
    parameter int ROT   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  din,
    output logic [IDX_W-1:0] dout
);
    localparam int CHUNKS = (IN_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = CHUNKS * IDX_W;
    localparam int SH     = ROT % IDX_W;

    logic [PAD_W-1:0] padded;
    logic [IDX_W-1:0] folded_d;

    assign padded = PAD_W'(din);

    always_comb begin
        folded_d = '0;
        for (int c = 0; c < CHUNKS; c++) begin
            folded_d ^= padded[c*IDX_W +: IDX_W];
        end
    end

    generate
        if (SH == 0) begin : g_norot
            assign dout = folded_d;
        end else begin : g_rot
            assign dout = {folded_d[IDX_W-1-SH:0], folded_d[IDX_W-1:IDX_W-SH]};
        end
    endgenerate

    // a rotation moves bits but never changes how many are set
    assert_rot_weight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dout) == $countones(folded_d));

endmodule

// File: rtl/sc_way_hashes.sv
module sc_way_hashes
    import sc_idx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int WAYS   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          addr,
    input  cf_t                        cf,
    output logic [WAYS-1:0][IDX_W-1:0] idx
);
    localparam int HI_W = ADDR_W - TAG_LO;
    localparam int IN_W = HI_W + OFF_W + GRP_W;

    logic [IN_W-1:0]  hin_d;
    logic [OFF_W-1:0] off_d;

    always_comb begin
        off_d = addr[OFF_W-1:0] & off_keep(cf);
        hin_d = {addr[ADDR_W-1:TAG_LO], off_d, cf};
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            sc_fold_rot #(.IN_W(IN_W), .IDX_W(IDX_W), .ROT(w)) u_hash (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (hin_d),
                .dout (idx[w])
            );
        end
    endgenerate

    function automatic logic [IDX_W-1:0] rotl(input logic [IDX_W-1:0] v, input int s);
        logic [IDX_W-1:0] r;
        for (int i = 0; i < IDX_W; i++) r[(i + s) % IDX_W] = v[i];
        return r;
    endfunction

    generate
        for (genvar k = 1; k < WAYS; k++) begin : g_chk
            assert_way_rotation_R7: assert property (@(posedge clk) disable iff (!rst_n)
                idx[k] == rotl(idx[0], k % IDX_W));
        end
    endgenerate

endmodule

// File: rtl/skew_index_gen.sv
module skew_index_gen
    import sc_idx_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 8,
    parameter int WAYS    = 4,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [ADDR_W-1:0]                           lookup_addr,
    output logic [NUM_GROUPS-1:0][GRP_W-1:0]            lookup_cf,
    output logic [NUM_GROUPS-1:0][WAYS-1:0][IDX_W-1:0]  lookup_idx,
    input  logic [ADDR_W-1:0]                           move_addr,
    input  logic [GRP_W-1:0]                            move_cf,
    output logic [GRP_W-1:0]                            move_group,
    output logic [WAYS-1:0][IDX_W-1:0]                  move_idx
);
    typedef struct packed {
        logic [NUM_GROUPS-1:0][GRP_W-1:0]           cf;
        logic [NUM_GROUPS-1:0][WAYS-1:0][IDX_W-1:0] idx;
        logic [GRP_W-1:0]                           mgrp;
        logic [WAYS-1:0][IDX_W-1:0]                 midx;
    } out_t;

    logic [NUM_GROUPS-1:0][GRP_W-1:0]           grp_cf_d;
    logic [NUM_GROUPS-1:0][WAYS-1:0][IDX_W-1:0] grp_idx_d;
    logic [WAYS-1:0][IDX_W-1:0]                 mv_idx_d;
    logic [GRP_W-1:0]                           mv_grp_d;
    out_t                                       st_d, st_q;

    // CF per way group: group-select tag bits XOR group number
    always_comb begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
            grp_cf_d[g] = lookup_addr[TAG_LO-1:SEL_LO] ^ GRP_W'(g);
        end
        mv_grp_d = move_addr[TAG_LO-1:SEL_LO] ^ move_cf;
    end

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            sc_way_hashes #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_lookup (
                .clk  (clk),
                .rst_n(rst_n),
                .addr (lookup_addr),
                .cf   (grp_cf_d[g]),
                .idx  (grp_idx_d[g])
            );
        end
    endgenerate

    sc_way_hashes #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_move (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (move_addr),
        .cf   (move_cf),
        .idx  (mv_idx_d)
    );

    always_comb begin
        st_d.cf   = grp_cf_d;
        st_d.idx  = grp_idx_d;
        st_d.mgrp = mv_grp_d;
        st_d.midx = mv_idx_d;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end
        end else begin : g_comb
            assign st_q = st_d;
        end
    endgenerate

    assign lookup_cf  = st_q.cf;
    assign lookup_idx = st_q.idx;
    assign move_group = st_q.mgrp;
    assign move_idx   = st_q.midx;

    // the move path and the lookup path must agree on where a CF lives
    assert_move_cf_agrees_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (move_addr == lookup_addr) |-> (grp_cf_d[mv_grp_d] == move_cf));

    assert_move_idx_agrees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (move_addr == lookup_addr) |-> (grp_idx_d[mv_grp_d] == mv_idx_d));

endmodule

// File: tb/tb_skew_index_gen.sv
module tb_skew_index_gen;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 8;
    localparam int WAYS   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] lookup_addr = '0;
    logic [3:0][1:0] lookup_cf;
    logic [3:0][WAYS-1:0][IDX_W-1:0] lookup_idx;
    logic [ADDR_W-1:0] move_addr = '0;
    logic [1:0] move_cf = '0;
    logic [1:0] move_group;
    logic [WAYS-1:0][IDX_W-1:0] move_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    skew_index_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .WAYS(WAYS)) dut (
        .clk(clk), .rst_n(rst_n),
        .lookup_addr(lookup_addr), .lookup_cf(lookup_cf), .lookup_idx(lookup_idx),
        .move_addr(move_addr), .move_cf(move_cf),
        .move_group(move_group), .move_idx(move_idx));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference from R4, R5, R7
    function automatic logic [2:0] keep(input logic [1:0] cf);
        case (cf)
            2'd0: return 3'b111;
            2'd1: return 3'b110;
            2'd2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] ref_idx(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] cf, input int way);
        logic [39:0] v;
        logic [IDX_W-1:0] f, r;
        v = 40'({a[ADDR_W-1:5], a[2:0] & keep(cf), cf});
        f = '0;
        for (int c = 0; c < 5; c++) f ^= v[c*8 +: 8];
        for (int i = 0; i < IDX_W; i++) r[(i + way) % IDX_W] = f[i];
        return r;
    endfunction

    task automatic apply(input logic [ADDR_W-1:0] la, input logic [ADDR_W-1:0] ma,
                         input logic [1:0] mc);
        @(negedge clk);
        lookup_addr = la; move_addr = ma; move_cf = mc;
        #1;
    endtask

    task automatic t_reset;
        apply('0, '0, 2'd0);
        for (int g = 0; g < 4; g++) chk("R1 reset cf", 32'(lookup_cf[g]), 32'(g));
        chk("R9 reset idx", 32'(lookup_idx[0][0]), 32'(ref_idx('0, 2'd0, 0)));
        chk("R2 reset group", 32'(move_group), 32'd0);
    endtask

    task automatic t_cf_map;
        for (int s = 0; s < 4; s++) begin
            logic [ADDR_W-1:0] a;
            a = 32'hA5C3_0000 | 32'(s << 3) | 32'h5;
            apply(a, a, 2'(3 - s));
            for (int g = 0; g < 4; g++) chk("R1 cf map", 32'(lookup_cf[g]), 32'(s ^ g));
            chk("R2 move group", 32'(move_group), 32'(s ^ (3 - s)));
        end
    endtask

    task automatic t_full_model;
        logic [ADDR_W-1:0] a = 32'h1234_5678;
        for (int n = 0; n < 40; n++) begin
            a = {a[30:0], a[31] ^ a[21] ^ a[1] ^ a[0]} ^ 32'(n * 977);
            apply(a, a ^ 32'h0001_0100, 2'(n));
            for (int g = 0; g < 4; g++)
                for (int w = 0; w < WAYS; w++)
                    chk("R4 R7 lookup idx", 32'(lookup_idx[g][w]),
                        32'(ref_idx(a, 2'(a[4:3] ^ 2'(g)), w)));
            for (int w = 0; w < WAYS; w++)
                chk("R4 move idx", 32'(move_idx[w]), 32'(ref_idx(a ^ 32'h0001_0100, 2'(n), w)));
        end
    endtask

    task automatic t_offsets;
        logic [IDX_W-1:0] got [8];
        logic [ADDR_W-1:0] base = 32'h0BAD_F00_0;
        for (int cf = 0; cf < 4; cf++) begin
            for (int o = 0; o < 8; o++) begin
                apply('0, base | 32'(o), 2'(cf));
                got[o] = move_idx[0];
            end
            for (int i = 0; i < 8; i++)
                for (int j = i + 1; j < 8; j++) begin
                    bit same = ((i & keep(2'(cf))) == (j & keep(2'(cf))));
                    if (same) chk("R6 ignored offset", 32'(got[i] == got[j]), 32'd1);
                    else chk("R5 kept offset", 32'(got[i] != got[j]), 32'd1);
                end
        end
    endtask

    task automatic t_sel_bits;
        for (int cf = 0; cf < 4; cf++) begin
            logic [WAYS-1:0][IDX_W-1:0] first;
            apply('0, 32'h7777_7002, 2'(cf));
            first = move_idx;
            for (int s = 1; s < 4; s++) begin
                apply('0, 32'h7777_7002 | 32'(s << 3), 2'(cf));
                chk("R3 select bits ignored", 32'(move_idx == first), 32'd1);
            end
        end
    endtask

    task automatic t_rotation;
        logic [ADDR_W-1:0] a = 32'hFFFF_FFFF;
        apply(a, a, 2'd1);
        for (int w = 1; w < WAYS; w++) begin
            logic [IDX_W-1:0] r;
            for (int i = 0; i < IDX_W; i++) r[(i + w) % IDX_W] = move_idx[0][i];
            chk("R7 way rotation", 32'(move_idx[w]), 32'(r));
        end
    endtask

    task automatic t_reverse;
        for (int n = 0; n < 16; n++) begin
            logic [ADDR_W-1:0] a = 32'h3C00_0000 + 32'(n * 4099);
            apply(a, a, 2'(n));
            chk("R8 move equals lookup", 32'(move_idx == lookup_idx[move_group]), 32'd1);
            chk("R8 cf at dest group", 32'(lookup_cf[move_group]), 32'(n % 4));
        end
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        lookup_addr = 32'h0000_0018;
        #0.5;
        chk("R9 same-cycle cf", 32'(lookup_cf[0]), 32'd3);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                t_reset();
                t_cf_map();
                t_full_model();
                t_offsets();
                t_sel_bits();
                t_rotation();
                t_reverse();
                t_same_cycle();
                done = 1'b1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog: actual=timeout expected=finish");
                end
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule